// File: doc/BRIEF.md
# UART FIFO DMA Request Logic

This block holds the transmit and receive character queues of one serial channel and turns their occupancy into two active-low DMA handshake outputs, a transmit-ready and a receive-ready. The host writes characters into the transmit queue and reads them from the receive queue. The serial side, which is not part of this block, takes characters from the transmit queue and deposits them into the receive queue. Both queue levels are visible at all times as count outputs.

A control byte sets the queue behaviour. When bit 0 is clear, each queue is a single-character holding register. When it is set, each queue holds up to 16 characters. Bit 3 chooses between single-transfer signalling and multi-character signalling. Multi-character signalling applies only while the queues are enabled. In that mode the receive request uses a programmable trigger level and keeps asserting until the queue has been drained. This lets a DMA controller move a burst without host involvement.

Top module: `uart_dma_ready`

## Requirements
- R1: While `rst` is high, `txrdy_n` and `rxrdy_n` are both 1. After the first clock edge with `rst` high, both counts read 0.
- R2: The effective mode is multi-character only when `ctrl[0]`=1 and `ctrl[3]`=1. With `ctrl[0]`=0 the single-transfer rules apply whatever `ctrl[3]` is.
- R3: In single-transfer mode, `txrdy_n` is 0 exactly while `tx_count` is 0. It goes to 1 from the clock edge that accepts a host write.
- R4: In single-transfer mode, `rxrdy_n` is 0 while `rx_count` is at least 1, and it returns to 1 once `rx_count` is 0.
- R5: Each count rises by one on an accepted push and falls by one on an accepted pop, and is updated at the clock edge that samples the strobe. A push and a pop accepted together leave the count unchanged.
- R6: Queue capacity is 16 with `ctrl[0]`=1 and 1 with `ctrl[0]`=0. A write to a full transmit queue, or a read from an empty receive queue, is ignored and the count does not change.
- R7: In multi-character mode, `txrdy_n` is 0 while `tx_count` is below 16, and it is 1 when `tx_count` is 16.
- R8: In multi-character mode, `ctrl[7:6]` selects the receive trigger level: 00→1, 01→4, 10→8, 11→14. `rxrdy_n` goes to 0 when `rx_count` reaches the trigger level and stays 0 until `rx_count` is 0.
- R9: `tx_empty` is 1 exactly when `tx_count` is 0. `rx_trig_hit` is 1 only in multi-character mode with `rx_count` at or above the trigger level, and is 0 in single-transfer mode.
- R10: Both queues are first-in first-out. `tx_data` and `host_rdata` always show the oldest held character.
- R11: A change of `ctrl[0]` empties both queues at the next clock edge, and strobes sampled at that edge are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl | input | 8 | Control byte: [0] queue enable, [3] multi-character mode, [7:6] receive trigger select |
| host_wr | input | 1 | Host write strobe into the transmit queue |
| host_wdata | input | 8 | Host write data |
| tx_pop | input | 1 | Serial side takes the oldest transmit character |
| tx_data | output | 8 | Oldest transmit character |
| rx_push | input | 1 | Serial side deposits a received character |
| rx_wdata | input | 8 | Received character |
| host_rd | input | 1 | Host read strobe from the receive queue |
| host_rdata | output | 8 | Oldest received character |
| tx_count | output | 5 | Transmit queue occupancy |
| rx_count | output | 5 | Receive queue occupancy |
| tx_empty | output | 1 | Transmit queue empty flag |
| rx_trig_hit | output | 1 | Receive level at or above trigger in multi-character mode |
| txrdy_n | output | 1 | Transmit DMA ready, active low |
| rxrdy_n | output | 1 | Receive DMA ready, active low |

## Verification
On every cycle, the assertions check that both ready outputs are idle in reset and that the counts are cleared after it. They also check that a count never exceeds the capacity set by the enable bit, that a write to a full queue or a read from an empty queue leaves the count alone, that a single-transfer write deasserts the transmit request, and that an asserted multi-character receive request persists while data remains. The bench scenarios show the remaining behaviour: the exact trigger levels for each select code, the first-in first-out data order, the flush on enable change, and that the multi-select bit has no effect while the queues are disabled.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

    localparam int DEF_DEPTH = 16;
    localparam int DEF_DW    = 8;

    typedef enum logic {
        DMA_SINGLE = 1'b0,
        DMA_MULTI  = 1'b1
    } dma_mode_e;

    // Control byte layout; only [0], [3] and [7:6] carry meaning.
    typedef struct packed {
        logic [1:0] trig_sel;
        logic [1:0] spare_hi;
        logic       multi_sel;
        logic [1:0] spare_lo;
        logic       fifo_on;
    } ctrl_t;

    localparam int CH_TX = 0;
    localparam int CH_RX = 1;

    function automatic dma_mode_e resolve_mode(ctrl_t c);
        return (c.fifo_on && c.multi_sel) ? DMA_MULTI : DMA_SINGLE;
    endfunction

    function automatic int unsigned trig_depth(logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_char_fifo.sv
module uart_char_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign push_ok = push && (count < cap);
    assign pop_ok  = pop && (count != '0);
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok && !flush && !rst) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/uart_dma_ready_gen.sv
module uart_dma_ready_gen
    import uart_dma_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  dma_mode_e     mode,
    input  logic [CW-1:0] cap,
    input  logic [CW-1:0] trig,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    output logic          txrdy_n,
    output logic          rxrdy_n,
    output logic          rx_trig_hit
);

    logic tx_req, rx_req, rx_hold;

    always_comb begin
        rx_trig_hit = (mode == DMA_MULTI) && (rx_count >= trig);
        if (mode == DMA_MULTI) begin
            tx_req = tx_count < cap;
            rx_req = rx_trig_hit || (rx_hold && rx_count != '0);
        end else begin
            tx_req = tx_count == '0;
            rx_req = rx_count != '0;
        end
    end

    // Remembers an asserted receive request so it lasts until drained.
    always_ff @(posedge clk) begin
        if (rst || flush) rx_hold <= 1'b0;
        else              rx_hold <= rx_req;
    end

    assign txrdy_n = rst || !tx_req;
    assign rxrdy_n = rst || !rx_req;

endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready
    import uart_dma_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int DW    = DEF_DW,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    ctrl,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_data,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_wdata,
    input  logic          host_rd,
    output logic [DW-1:0] host_rdata,
    output logic [CW-1:0] tx_count,
    output logic [CW-1:0] rx_count,
    output logic          tx_empty,
    output logic          rx_trig_hit,
    output logic          txrdy_n,
    output logic          rxrdy_n
);

    ctrl_t         cfg;
    dma_mode_e     mode;
    logic          en_q, flush;
    logic [CW-1:0] cap, trig;
    logic [3:0]    cfg_unused;

    assign cfg        = ctrl_t'(ctrl);
    assign cfg_unused = {cfg.spare_hi, cfg.spare_lo};
    assign mode       = resolve_mode(cfg);
    assign cap        = cfg.fifo_on ? CW'(DEPTH) : CW'(1);
    assign trig       = CW'(trig_depth(cfg.trig_sel));

    // Tracks the enable bit in and out of reset so only a real change flushes.
    always_ff @(posedge clk) en_q <= cfg.fifo_on;
    assign flush = cfg.fifo_on ^ en_q;

    logic          q_push [2];
    logic          q_pop  [2];
    logic [DW-1:0] q_wdat [2];
    logic [DW-1:0] q_rdat [2];
    logic [CW-1:0] q_cnt  [2];

    assign q_push[CH_TX] = host_wr;
    assign q_pop[CH_TX]  = tx_pop;
    assign q_wdat[CH_TX] = host_wdata;
    assign q_push[CH_RX] = rx_push;
    assign q_pop[CH_RX]  = host_rd;
    assign q_wdat[CH_RX] = rx_wdata;

    for (genvar g = 0; g < 2; g++) begin : g_queue
        uart_char_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .flush (flush),
            .cap   (cap),
            .push  (q_push[g]),
            .wdata (q_wdat[g]),
            .pop   (q_pop[g]),
            .rdata (q_rdat[g]),
            .count (q_cnt[g])
        );
    end

    assign tx_data    = q_rdat[CH_TX];
    assign host_rdata = q_rdat[CH_RX];
    assign tx_count   = q_cnt[CH_TX];
    assign rx_count   = q_cnt[CH_RX];
    assign tx_empty   = q_cnt[CH_TX] == '0;

    uart_dma_ready_gen #(.CW(CW)) u_ready (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .mode        (mode),
        .cap         (cap),
        .trig        (trig),
        .tx_count    (q_cnt[CH_TX]),
        .rx_count    (q_cnt[CH_RX]),
        .txrdy_n     (txrdy_n),
        .rxrdy_n     (rxrdy_n),
        .rx_trig_hit (rx_trig_hit)
    );

endmodule

// File: rtl/uart_dma_ready_chk.sv
module uart_dma_ready_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic [7:0]    ctrl,
    input logic          host_wr,
    input logic          tx_pop,
    input logic          rx_push,
    input logic          host_rd,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic          txrdy_n,
    input logic          rxrdy_n
);

    logic          single_mode, multi_mode;
    logic [CW-1:0] lim;

    assign multi_mode  = ctrl[0] && ctrl[3];
    assign single_mode = !multi_mode;
    assign lim         = ctrl[0] ? CW'(DEPTH) : CW'(1);

    // R1
    p_reset_idle_r1: assert property (@(posedge clk) rst |-> (txrdy_n && rxrdy_n));
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (tx_count == '0 && rx_count == '0));

    // R3
    p_tx_single_r3: assert property (@(posedge clk) disable iff (rst)
        (single_mode && host_wr && !tx_pop && tx_count == '0) |=> ($stable(ctrl) -> txrdy_n));

    // R6
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));
    p_disabled_depth_r6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl[0] && $stable(ctrl[0])) |-> (tx_count <= CW'(1) && rx_count <= CW'(1)));
    p_full_write_r6: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !tx_pop && tx_count == lim && $stable(ctrl[0])) |=> (tx_count == $past(tx_count)));
    p_empty_read_r6: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !rx_push && rx_count == '0) |=> (rx_count == '0));

    // R8
    p_rx_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (multi_mode && !rxrdy_n) |=> (($stable(ctrl) && rx_count != '0) -> !rxrdy_n));

endmodule

bind uart_dma_ready uart_dma_ready_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .host_wr  (host_wr),
    .tx_pop   (tx_pop),
    .rx_push  (rx_push),
    .host_rd  (host_rd),
    .tx_count (tx_count),
    .rx_count (rx_count),
    .txrdy_n  (txrdy_n),
    .rxrdy_n  (rxrdy_n)
);

// File: tb/tb_uart_dma_ready.sv
module tb_uart_dma_ready;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ctrl = 8'h00;
    logic       host_wr = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00, rx_wdata = 8'h00;
    logic [7:0] tx_data, host_rdata;
    logic [4:0] tx_count, rx_count;
    logic       tx_empty, rx_trig_hit, txrdy_n, rxrdy_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    uart_dma_ready dut (
        .clk(clk), .rst(rst), .ctrl(ctrl),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .tx_pop(tx_pop), .tx_data(tx_data),
        .rx_push(rx_push), .rx_wdata(rx_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata),
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_empty(tx_empty), .rx_trig_hit(rx_trig_hit),
        .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n)
    );

    typedef struct packed {
        logic [7:0] c;
        logic       wr, pop, push, rd;
        logic [4:0] tc, rc;
        logic       txn, rxn;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  5'd0, 1'b0, 1'b1}, // R3 empty tx asserts
        '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1,  5'd0, 1'b1, 1'b1}, // R3 one char deasserts
        '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1,  5'd0, 1'b1, 1'b1}, // R6 holding reg full
        '{8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  5'd0, 1'b0, 1'b1}, // R5 pop
        '{8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  5'd1, 1'b0, 1'b0}, // R4 rx asserts
        '{8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  5'd1, 1'b0, 1'b0}, // R6 rx full
        '{8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0,  5'd0, 1'b0, 1'b1}, // R4 rx drained
        '{8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0,  5'd0, 1'b0, 1'b1}, // R6 empty read
        '{8'h08, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  5'd1, 1'b0, 1'b0}, // R2 multi bit ignored
        '{8'h08, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0,  5'd0, 1'b0, 1'b1}, // R2
        '{8'h49, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  5'd0, 1'b0, 1'b1}, // R11 enable flush
        '{8'h49, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  5'd1, 1'b0, 1'b1}, // R8 below trigger 4
        '{8'h49, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  5'd2, 1'b0, 1'b1},
        '{8'h49, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  5'd3, 1'b0, 1'b1},
        '{8'h49, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  5'd4, 1'b0, 1'b0}, // R8 trigger reached
        '{8'h49, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0,  5'd3, 1'b0, 1'b0}, // R8 hold
        '{8'h49, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0,  5'd2, 1'b0, 1'b0},
        '{8'h49, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0,  5'd1, 1'b0, 1'b0},
        '{8'h49, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0,  5'd0, 1'b0, 1'b1}, // R8 released on empty
        '{8'h49, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1,  5'd0, 1'b0, 1'b1}, // R7 room left
        '{8'h49, 1'b1, 1'b1, 1'b0, 1'b0, 5'd1,  5'd0, 1'b0, 1'b1}  // R5 push and pop
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the next rising edge.
    task automatic tick(input logic [7:0] c, input logic wr, input logic pop,
                        input logic push, input logic rd,
                        input logic [7:0] wd, input logic [7:0] rxd);
        @(negedge clk);
        ctrl = c; host_wr = wr; tx_pop = pop; rx_push = push; host_rd = rd;
        host_wdata = wd; rx_wdata = rxd;
        @(posedge clk);
        #1;
        host_wr = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; host_rd = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (2) @(posedge clk);
        #1;
        check("R1 ready idle in reset", {txrdy_n, rxrdy_n}, 2'b11);
        check("R1 counts cleared", {tx_count, rx_count}, 10'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;

        // Vector table: R2 R3 R4 R5 R6 R7 R8 R11
        for (int i = 0; i < NV; i++) begin
            tick(VECS[i].c, VECS[i].wr, VECS[i].pop, VECS[i].push, VECS[i].rd,
                 8'(i), 8'(8'h40 + i));
            checks++;
            if ({tx_count, rx_count, txrdy_n, rxrdy_n} !==
                {VECS[i].tc, VECS[i].rc, VECS[i].txn, VECS[i].rxn}) begin
                fails++;
                $display("FAIL table row %0d actual tc=%0d rc=%0d txn=%b rxn=%b expected tc=%0d rc=%0d txn=%b rxn=%b",
                         i, tx_count, rx_count, txrdy_n, rxrdy_n,
                         VECS[i].tc, VECS[i].rc, VECS[i].txn, VECS[i].rxn);
            end
        end

        // R11 flush by toggling enable off then on
        tick(8'h00, 0, 0, 0, 0, 8'h00, 8'h00);
        check("R11 flush on disable", tx_count, 5'd0);
        tick(8'h49, 0, 0, 0, 0, 8'h00, 8'h00);
        check("R11 flush on enable", tx_count, 5'd0);

        // R7 fill transmit queue in multi mode
        for (int k = 0; k < 16; k++) tick(8'h49, 1, 0, 0, 0, 8'(8'hA0 + k), 8'h00);
        check("R7 full count", tx_count, 5'd16);
        check("R7 full deasserts", txrdy_n, 1'b1);
        tick(8'h49, 1, 0, 0, 0, 8'hEE, 8'h00);
        check("R6 write to full ignored", tx_count, 5'd16);
        check("R10 head kept", tx_data, 8'hA0);
        tick(8'h49, 0, 1, 0, 0, 8'h00, 8'h00);
        check("R7 room reasserts", {tx_count, txrdy_n}, {5'd15, 1'b0});
        check("R9 tx_empty low", tx_empty, 1'b0);
        for (int k = 1; k < 16; k++) begin
            check("R10 tx order", tx_data, 8'(8'hA0 + k));
            tick(8'h49, 0, 1, 0, 0, 8'h00, 8'h00);
        end
        check("R9 tx_empty high", tx_empty, 1'b1);

        // R8 trigger 14
        tick(8'hC9, 0, 0, 0, 0, 8'h00, 8'h00);
        for (int k = 0; k < 13; k++) tick(8'hC9, 0, 0, 1, 0, 8'h00, 8'(8'h30 + k));
        check("R8 below trigger 14", {rx_count, rxrdy_n, rx_trig_hit}, {5'd13, 1'b1, 1'b0});
        tick(8'hC9, 0, 0, 1, 0, 8'h00, 8'h3D);
        check("R8 at trigger 14", {rx_count, rxrdy_n, rx_trig_hit}, {5'd14, 1'b0, 1'b1});
        for (int k = 0; k < 13; k++) begin
            check("R10 rx order", host_rdata, 8'(8'h30 + k));
            tick(8'hC9, 0, 0, 0, 1, 8'h00, 8'h00);
        end
        check("R8 held while draining", {rx_count, rxrdy_n, rx_trig_hit}, {5'd1, 1'b0, 1'b0});
        check("R10 last rx", host_rdata, 8'h3D);
        tick(8'hC9, 0, 0, 0, 1, 8'h00, 8'h00);
        check("R8 released at empty", rxrdy_n, 1'b1);

        // R8 trigger 8
        for (int k = 0; k < 7; k++) tick(8'h89, 0, 0, 1, 0, 8'h00, 8'h55);
        check("R8 below trigger 8", rxrdy_n, 1'b1);
        tick(8'h89, 0, 0, 1, 0, 8'h00, 8'h55);
        check("R8 at trigger 8", {rxrdy_n, rx_trig_hit}, 2'b01);

        // R11 disabling flushes held data
        tick(8'h88, 0, 0, 0, 0, 8'h00, 8'h00);
        check("R11 rx flushed", {rx_count, rxrdy_n}, {5'd0, 1'b1});

        // R2 multi bit has no effect while disabled
        tick(8'h08, 1, 0, 0, 0, 8'h77, 8'h00);
        check("R2 single rules while disabled", {tx_count, txrdy_n}, {5'd1, 1'b1});
        tick(8'h08, 1, 0, 1, 0, 8'h78, 8'h66);
        check("R6 disabled depth one", tx_count, 5'd1);
        check("R9 trig flag low in single", {rx_count, rxrdy_n, rx_trig_hit}, {5'd1, 1'b0, 1'b0});

        // R1 reset while data held
        @(negedge clk);
        rst = 1'b1;
        #1;
        check("R1 ready forced idle", {txrdy_n, rxrdy_n}, 2'b11);
        @(posedge clk);
        #1;
        check("R1 counts cleared by reset", {tx_count, rx_count}, 10'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 after release", {txrdy_n, rxrdy_n, tx_empty}, 3'b011);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule